// File: doc/BRIEF.md
# Exception Priority Mask Filter

This block sits beside an exception controller. Each cycle it decides whether the single pending exception offered at its input may be taken now. The decision depends on three mask registers kept inside the block:

- a one-bit interrupt mask;
- a one-bit fault mask;
- a priority threshold that blocks exceptions by their priority number.

Each exception arrives with a two-bit class and a priority number, where a larger number means lower urgency. The block answers with a combinational take signal.

Software changes the single-bit masks with dedicated set and clear strobes. It changes any of the three registers through a general write port that selects a register and carries its whole value. A read port returns any register's value combinationally. A change to any register becomes visible to the decision from the cycle after the clock edge that captured it.

The threshold is `PRIO_W` bits wide as seen by software. Only the top `IMPL_W` bits are stored; the remaining low bits always read as zero. The comparison uses only those top bits of both the threshold and the incoming priority.

Top module: `exc_mask_filter`

## Requirements
- R1: After reset the interrupt mask, the fault mask and the threshold are all 0, so every valid exception is taken.
- R2: An exception of class 0 (non-maskable) is always taken when `exc_valid` is 1, whatever the mask state.
- R3: When the interrupt mask is 1 and the fault mask is 0, classes 2 (general fault) and 3 (interrupt) are blocked, while classes 0 and 1 (hard fault) are taken.
- R4: When the fault mask is 1, every class except class 0 is blocked, hard fault included.
- R5: With a nonzero threshold, a class 2 or 3 exception is blocked when the upper `IMPL_W` bits of its priority are greater than or equal to the stored threshold bits. It is taken when they are smaller. Classes 0 and 1 ignore the threshold.
- R6: A threshold of zero blocks nothing, for any priority value.
- R7: A threshold write keeps only bits `[PRIO_W-1 -: IMPL_W]` of the written value. Reading the threshold returns those bits with all lower bits 0.
- R8: `set_imask`/`clr_imask` and `set_fmask`/`clr_fmask` set or clear their mask on the next edge. When set and clear of the same mask come together, the mask becomes 1.
- R9: Register select encoding for `wr_sel` and `rd_sel`: 0 = interrupt mask (data bit 0, other bits read 0), 1 = fault mask (data bit 0), 2 = threshold, 3 = no register (writes ignored, reads return 0).
- R10: A register write or command changes the decision only from the next cycle. A set or clear command for a mask overrides a write to that same mask in the same cycle.
- R11: `take` is 0 whenever `exc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_imask | input | 1 | Set interrupt mask |
| clr_imask | input | 1 | Clear interrupt mask |
| set_fmask | input | 1 | Set fault mask |
| clr_fmask | input | 1 | Clear fault mask |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for write |
| wr_data | input | PRIO_W | Write value |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | PRIO_W | Read value |
| exc_valid | input | 1 | An exception is pending |
| exc_class | input | 2 | 0 non-maskable, 1 hard fault, 2 general fault, 3 interrupt |
| exc_prio | input | PRIO_W | Priority number of the pending exception |
| take | output | 1 | Exception may be taken this cycle |

## Verification
The bench covers the layering of masks, one corner at a time:

- **Hard fault under the interrupt mask.** A design that let the interrupt mask reach too far would block hard fault there.
- **Hard fault under the fault mask.** A design that exempted hard fault from the fault mask would still take it.
- **Priority equal to the threshold.** An off-by-one compare would take that exception.
- **Priority just below the threshold.** An off-by-one compare in the other direction would block it.
- **Threshold set to zero.** A design that compared against zero literally would block everything.
- **Threshold written with only low bits set.** A design that stored all bits would read back nonzero and start blocking.
- **Set and clear in the same cycle.** Wrong precedence leaves the mask at 0.
- **Command and write to the same mask in the same cycle.** Wrong precedence lets the write win.
- **Exception presented in the same cycle as a threshold write.** A design that forwarded the written value would decide one cycle early.

// File: rtl/exc_mask_filter.sv
module exc_mask_filter #(
  parameter int PRIO_W = 8,
  parameter int IMPL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_imask,
  input  logic              clr_imask,
  input  logic              set_fmask,
  input  logic              clr_fmask,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [PRIO_W-1:0] rd_data,
  input  logic              exc_valid,
  input  logic [1:0]        exc_class,
  input  logic [PRIO_W-1:0] exc_prio,
  output logic              take
);
  localparam int LOW_W = PRIO_W - IMPL_W;
  localparam logic [1:0] CL_NMI = 2'd0;
  localparam logic [1:0] CL_HF  = 2'd1;
  localparam logic [1:0] SEL_IM = 2'd0;
  localparam logic [1:0] SEL_FM = 2'd1;
  localparam logic [1:0] SEL_TH = 2'd2;

  logic              imask, fmask;
  logic [IMPL_W-1:0] thr;
  logic [IMPL_W-1:0] prio_hi;
  logic              thr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          imask <= 1'b0;
    else if (set_imask)                  imask <= 1'b1;
    else if (clr_imask)                  imask <= 1'b0;
    else if (wr_en && wr_sel == SEL_IM)  imask <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          fmask <= 1'b0;
    else if (set_fmask)                  fmask <= 1'b1;
    else if (clr_fmask)                  fmask <= 1'b0;
    else if (wr_en && wr_sel == SEL_FM)  fmask <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          thr <= '0;
    else if (wr_en && wr_sel == SEL_TH)  thr <= wr_data[PRIO_W-1 -: IMPL_W];
  end

  assign prio_hi = exc_prio[PRIO_W-1 -: IMPL_W];
  assign thr_hit = (thr != '0) && (prio_hi >= thr);

  always_comb begin
    take = 1'b0;
    if (exc_valid) begin
      if (exc_class == CL_NMI)     take = 1'b1;
      else if (fmask)              take = 1'b0;
      else if (exc_class == CL_HF) take = 1'b1;
      else                         take = !imask && !thr_hit;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_IM:  rd_data = PRIO_W'(imask);
      SEL_FM:  rd_data = PRIO_W'(fmask);
      SEL_TH:  rd_data = PRIO_W'(thr) << LOW_W;
      default: rd_data = '0;
    endcase
  end

  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_class == CL_NMI |-> take); // R2
  AST_FMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fmask && exc_valid && exc_class != CL_NMI |-> !take); // R4
  AST_HF_PASSES_IMASK: assert property (@(posedge clk) disable iff (!rst_n)
    !fmask && exc_valid && exc_class == CL_HF |-> take); // R3
  AST_ISET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_imask |=> imask); // R8
  AST_FSET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_fmask |=> fmask); // R8
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> !take); // R11
  AST_THR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_TH) |=> $stable(thr)); // R10
endmodule

// File: tb/exc_mask_filter_test.sv
module exc_mask_filter_test;
  localparam int PRIO_W = 8;
  localparam int IMPL_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_imask = 0, clr_imask = 0, set_fmask = 0, clr_fmask = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0, exc_class = 0;
  logic [PRIO_W-1:0] wr_data = 0, exc_prio = 0;
  logic exc_valid = 0;
  logic [PRIO_W-1:0] rd_data;
  logic take;

  always #10 clk = ~clk;

  exc_mask_filter #(.PRIO_W(PRIO_W), .IMPL_W(IMPL_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .set_imask(set_imask), .clr_imask(clr_imask),
    .set_fmask(set_fmask), .clr_fmask(clr_fmask),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .exc_valid(exc_valid), .exc_class(exc_class), .exc_prio(exc_prio),
    .take(take));

  typedef struct {
    logic              t;
    logic [PRIO_W-1:0] r;
    string             tag;
  } item_t;
  item_t q[$];

  int tests = 0, fails = 0;
  bit done = 0;

  logic              im_m = 0, fm_m = 0;
  logic [PRIO_W-1:0] th_m = 0;

  function automatic logic exp_take(logic v, logic [1:0] c, logic [PRIO_W-1:0] p);
    if (!v) return 1'b0;
    if (c == 2'd0) return 1'b1;
    if (fm_m) return 1'b0;
    if (c == 2'd1) return 1'b1;
    if (im_m) return 1'b0;
    if (th_m != 0 && p[PRIO_W-1 -: IMPL_W] >= th_m[PRIO_W-1 -: IMPL_W]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [PRIO_W-1:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0: return PRIO_W'(im_m);
      2'd1: return PRIO_W'(fm_m);
      2'd2: return th_m;
      default: return '0;
    endcase
  endfunction

  task automatic step(input logic v, input logic [1:0] c, input logic [PRIO_W-1:0] p,
                      input logic si, input logic ci, input logic sf, input logic cf,
                      input logic we, input logic [1:0] ws, input logic [PRIO_W-1:0] wd,
                      input logic [1:0] rs, input string tag);
    item_t it;
    @(negedge clk);
    exc_valid = v; exc_class = c; exc_prio = p;
    set_imask = si; clr_imask = ci; set_fmask = sf; clr_fmask = cf;
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    it.t = exp_take(v, c, p);
    it.r = exp_rd(rs);
    it.tag = tag;
    q.push_back(it);
    if (si) im_m = 1'b1;
    else if (ci) im_m = 1'b0;
    else if (we && ws == 2'd0) im_m = wd[0];
    if (sf) fm_m = 1'b1;
    else if (cf) fm_m = 1'b0;
    else if (we && ws == 2'd1) fm_m = wd[0];
    if (we && ws == 2'd2) th_m = wd & 8'hE0;
  endtask

  task automatic chk(input logic [1:0] c, input logic [PRIO_W-1:0] p,
                     input logic [1:0] rs, input string tag);
    step(1'b1, c, p, 0, 0, 0, 0, 0, 2'd0, 8'h00, rs, tag);
  endtask

  always @(negedge clk) begin
    item_t it;
    #5;
    if (q.size() > 0) begin
      it = q.pop_front();
      tests++;
      if (take !== it.t || rd_data !== it.r) begin
        fails++;
        $display("FAIL %s: take=%b rd=%h expected take=%b rd=%h",
                 it.tag, take, rd_data, it.t, it.r);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    chk(2'd3, 8'hFF, 2'd0, "R1 reset imask");
    chk(2'd3, 8'hFF, 2'd1, "R1 reset fmask");
    chk(2'd2, 8'hFF, 2'd2, "R1 reset threshold");
    chk(2'd3, 8'h00, 2'd3, "R9 unused select reads zero");
    step(1'b0, 2'd0, 8'h00, 0, 0, 0, 0, 0, 2'd0, 8'h00, 2'd0, "R11 no valid");
    chk(2'd0, 8'hFF, 2'd0, "R2 nmi");
    step(1'b1, 2'd3, 8'h00, 1, 0, 0, 0, 0, 2'd0, 8'h00, 2'd0, "R10 set takes effect next cycle");
    chk(2'd3, 8'h00, 2'd0, "R3 imask blocks interrupt");
    chk(2'd2, 8'h00, 2'd0, "R3 imask blocks fault");
    chk(2'd1, 8'hFF, 2'd0, "R3 hard fault passes imask");
    chk(2'd0, 8'hFF, 2'd0, "R2 nmi passes imask");
    step(1'b1, 2'd3, 8'h00, 0, 1, 0, 0, 0, 2'd0, 8'h00, 2'd0, "R8 clear");
    chk(2'd3, 8'h00, 2'd0, "R8 cleared imask");
    step(1'b1, 2'd3, 8'h00, 1, 1, 0, 0, 0, 2'd0, 8'h00, 2'd0, "R8 set+clear");
    chk(2'd3, 8'h00, 2'd0, "R8 set wins imask");
    step(1'b1, 2'd1, 8'h00, 0, 1, 1, 1, 0, 2'd0, 8'h00, 2'd1, "R8 fmask set+clear");
    chk(2'd1, 8'h00, 2'd1, "R4 fmask blocks hard fault");
    chk(2'd3, 8'h00, 2'd1, "R4 fmask blocks interrupt");
    chk(2'd0, 8'hFF, 2'd1, "R4 nmi passes fmask");
    step(1'b1, 2'd1, 8'h00, 0, 0, 0, 1, 0, 2'd0, 8'h00, 2'd1, "R8 clear fmask");
    step(1'b1, 2'd3, 8'hFF, 0, 0, 0, 0, 1, 2'd2, 8'h47, 2'd2, "R10 thr write same cycle");
    chk(2'd3, 8'hFF, 2'd2, "R7 threshold low bits dropped");
    chk(2'd3, 8'h40, 2'd2, "R5 equal priority blocked");
    chk(2'd3, 8'h3F, 2'd2, "R5 lower number taken");
    chk(2'd2, 8'h5F, 2'd2, "R7 low priority bits ignored");
    chk(2'd1, 8'hFF, 2'd2, "R5 hard fault ignores threshold");
    chk(2'd0, 8'hFF, 2'd2, "R5 nmi ignores threshold");
    step(1'b1, 2'd3, 8'h20, 0, 0, 0, 0, 1, 2'd2, 8'h20, 2'd2, "R10 old threshold still used");
    chk(2'd3, 8'h20, 2'd2, "R10 new threshold applies");
    step(1'b1, 2'd3, 8'hFF, 0, 0, 0, 0, 1, 2'd2, 8'h00, 2'd2, "R6 write zero");
    chk(2'd3, 8'hFF, 2'd2, "R6 zero threshold passes 0xFF");
    chk(2'd2, 8'h00, 2'd2, "R6 zero threshold passes 0x00");
    step(1'b1, 2'd3, 8'hFF, 0, 0, 0, 0, 1, 2'd2, 8'h1F, 2'd2, "R7 write low bits only");
    chk(2'd3, 8'hFF, 2'd2, "R7 low-only write reads zero");
    step(1'b1, 2'd3, 8'h00, 0, 0, 0, 0, 1, 2'd0, 8'h01, 2'd0, "R9 write imask");
    chk(2'd3, 8'h00, 2'd0, "R9 imask written");
    step(1'b1, 2'd3, 8'h00, 0, 0, 0, 0, 1, 2'd3, 8'hFF, 2'd3, "R9 unused select write");
    chk(2'd3, 8'h00, 2'd3, "R9 unused write ignored");
    chk(2'd3, 8'h00, 2'd0, "R9 imask kept after unused write");
    step(1'b1, 2'd1, 8'h00, 0, 0, 0, 0, 1, 2'd1, 8'h01, 2'd1, "R9 write fmask");
    chk(2'd1, 8'h00, 2'd1, "R9 fmask written");
    step(1'b1, 2'd1, 8'h00, 0, 0, 0, 0, 1, 2'd1, 8'h00, 2'd1, "R9 write fmask zero");
    step(1'b1, 2'd3, 8'h00, 0, 1, 0, 0, 1, 2'd0, 8'h01, 2'd0, "R10 clear vs write");
    chk(2'd3, 8'h00, 2'd0, "R10 clear beats write");
    @(negedge clk);
    exc_valid = 0; wr_en = 0; set_imask = 0; clr_imask = 0;
    #10;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule